// File: doc/BRIEF.md
# 24-bit Periodic Tick Timer

This block is a periodic down-counting timer that produces a regular tick for an exception controller. A 24-bit counter counts down to zero and then reloads from a programmable reload register, so the tick period is the reload value plus one count. Each count is either one core clock cycle or one rising edge of an external reference input. The reference input is brought into the core clock domain through a two-flop synchronizer before its edges are detected.

Software uses a small register port with a 2-bit select and separate read and write strobes. A control/status register holds the run enable, the tick interrupt enable, the clock-source select and a sticky "wrapped" flag. That flag is cleared when the control register is read. Writing any value to the current-count register zeroes the counter and the flag. A read-only calibration register reports whether an external reference exists, whether the calibration count is exact, and a 10 ms count. While the debug-halt input is high, the counter holds its value.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-count registers all read as 0, and `tick_irq` is low.
- R2: Register select codes are 0 = control, 1 = reload, 2 = current count and 3 = calibration. The control fields are run enable at bit 0, interrupt enable at bit 1, source at bit 2 (1 = core clock, 0 = external reference) and the wrapped flag at bit 16. Unused bits read 0. Reload occupies bits 23:0.
- R3: When the core clock is selected and run is set, the count drops by one on every clock. On a count at 0 it loads the reload value instead.
- R4: When the external reference is selected, the count changes once for each rising edge of `ext_ref`. The edge is seen through a two-flop synchronizer, so the count changes on the third clock edge after `ext_ref` rises.
- R5: A count step from 1 to 0 sets the wrapped flag. A read of the control register returns the flag and clears it. If a wrap and that read fall in the same cycle, the flag stays set.
- R6: When the interrupt enable is set, `tick_irq` is high for exactly one cycle after each 1-to-0 step. When the interrupt enable is clear, `tick_irq` stays low.
- R7: A write of any value to the current-count register zeroes the counter and the flag and raises no interrupt. It takes priority over a count step in the same cycle.
- R8: While `dbg_halt` is high, the count does not change.
- R9: With a reload value of 0, the counter stays at 0 and produces no further flags or interrupts.
- R10: The calibration register reads bit 31 = no-reference, bit 30 = inexact and bits 23:0 = 10 ms count. These come from parameters (defaults 0, 0 and 500000). Writes to it have no effect.
- R11: With run clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe (causes read side effects) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| ext_ref | input | 1 | External reference, asynchronous |
| dbg_halt | input | 1 | Debug halt; freezes counting |
| tick_irq | output | 1 | One-cycle tick exception request |

## Verification
Two events can collide in one cycle, and both collisions decide what software sees. The first is the counter's 1-to-0 step against a read of the control register, which clears the flag. The second is a count step against a write to the current-count register. Directed runs with a small reload value read the control register on every cycle and write the count register while it is moving, so both collisions occur at known points. Random traffic with small reload values then repeats them many times, and every read and every `tick_irq` cycle is compared with a cycle model in the bench.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_CALIB   = 2'd3
  } tick_sel_e;

  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_IRQEN_BIT = 1;
  localparam int unsigned CTRL_SRC_BIT   = 2;
  localparam int unsigned CTRL_FLAG_BIT  = 16;
  localparam int unsigned CAL_NOREF_BIT  = 31;
  localparam int unsigned CAL_SKEW_BIT   = 30;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } tick_ctrl_t;
endpackage

// File: rtl/tick_refsync.sv
module tick_refsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic ref_rise
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], ref_async};
  end

  // chain_q[LAST-1] is the synchronized level; chain_q[LAST] is it delayed
  assign ref_rise = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clear,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] next_value(input logic [W-1:0] cur,
                                              input logic [W-1:0] rl);
    return (cur == '0) ? rl : cur - ONE;
  endfunction

  assign wrap = step & ~clear & (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= next_value(count, reload);
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned   W         = 24,
  parameter int unsigned   DW        = 32,
  parameter logic          CAL_NOREF = 1'b0,
  parameter logic          CAL_SKEW  = 1'b0,
  parameter logic [W-1:0]  CAL_TENMS = W'(500000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  count,
  input  logic          wrap,
  output logic [DW-1:0] rdata,
  output tick_ctrl_t    ctrl,
  output logic [W-1:0]  reload,
  output logic          flag,
  output logic          irq,
  output logic          cur_wr
);
  tick_sel_e sel_e;
  logic      ctl_wr, rl_wr, ctl_rd;

  assign sel_e  = tick_sel_e'(sel);
  assign ctl_wr = wr & (sel_e == SEL_CTRL);
  assign rl_wr  = wr & (sel_e == SEL_RELOAD);
  assign cur_wr = wr & (sel_e == SEL_CURRENT);
  assign ctl_rd = rd & (sel_e == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (ctl_wr) ctrl <= '{src_core: wdata[CTRL_SRC_BIT],
                             irq_en:   wdata[CTRL_IRQEN_BIT],
                             run:      wdata[CTRL_RUN_BIT]};
      if (rl_wr)  reload <= wdata[W-1:0];
    end
  end

  // software clear wins; a wrap wins over a read-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (cur_wr) flag <= 1'b0;
    else if (wrap)   flag <= 1'b1;
    else if (ctl_rd) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap & ctrl.irq_en;
  end

  always_comb begin
    rdata = '0;
    case (sel_e)
      SEL_CTRL: begin
        rdata[CTRL_RUN_BIT]   = ctrl.run;
        rdata[CTRL_IRQEN_BIT] = ctrl.irq_en;
        rdata[CTRL_SRC_BIT]   = ctrl.src_core;
        rdata[CTRL_FLAG_BIT]  = flag;
      end
      SEL_RELOAD:  rdata[W-1:0] = reload;
      SEL_CURRENT: rdata[W-1:0] = count;
      default: begin
        rdata[CAL_NOREF_BIT] = CAL_NOREF;
        rdata[CAL_SKEW_BIT]  = CAL_SKEW;
        rdata[W-1:0]         = CAL_TENMS;
      end
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned          CNT_W     = 24,
  parameter int unsigned          DATA_W    = 32,
  parameter int unsigned          SYNC_N    = 2,
  parameter logic                 CAL_NOREF = 1'b0,
  parameter logic                 CAL_SKEW  = 1'b0,
  parameter logic [CNT_W-1:0]     CAL_TENMS = CNT_W'(500000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_ref,
  input  logic              dbg_halt,
  output logic              tick_irq
);
  tick_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] reload_q, count_q;
  logic             ref_rise, tick_evt, wrap_evt, cur_wr, flag_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

  tick_refsync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async(ext_ref), .ref_rise(ref_rise)
  );

  assign tick_evt = ctrl_q.run & ~dbg_halt & (ctrl_q.src_core | ref_rise);

  tick_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(tick_evt), .clear(cur_wr),
    .reload(reload_q), .count(count_q), .wrap(wrap_evt)
  );

  tick_regs #(
    .W(CNT_W), .DW(DATA_W), .CAL_NOREF(CAL_NOREF),
    .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .count(count_q), .wrap(wrap_evt), .rdata(reg_rdata),
    .ctrl(ctrl_q), .reload(reload_q), .flag(flag_q), .irq(tick_irq),
    .cur_wr(cur_wr)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dbg_halt,
  input logic         run,
  input logic         cur_wr,
  input logic         wrap_evt,
  input logic         tick_irq,
  input logic         flag_q,
  input logic [W-1:0] count_q,
  input logic [W-1:0] reload_q
);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
  // R6
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (count_q == '0) && ($past(count_q) == W'(1)));
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);
  // R7
  swclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (count_q == '0) && !flag_q && !tick_irq);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !cur_wr) |=> $stable(count_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cur_wr) |=> $stable(count_q));
  // R9
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && reload_q == '0 && !cur_wr) |=> (count_q == '0) && !tick_irq);
endmodule

bind tick_timer tick_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .run(ctrl_q.run),
  .cur_wr(cur_wr), .wrap_evt(wrap_evt), .tick_irq(tick_irq),
  .flag_q(flag_q), .count_q(count_q), .reload_q(reload_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_in = 1'b0, halt = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] last_rd;
  bit done = 0;

  localparam logic [31:0] CAL_EXP = 32'd500000;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .ext_ref(ref_in),
    .dbg_halt(halt), .tick_irq(irq)
  );

  // bench cycle model
  logic        m_en, m_ie, m_src, m_flag, m_irq, m_s1, m_s2, m_s3;
  logic [23:0] m_cur, m_rel;

  function automatic logic [23:0] after_step(input logic [23:0] c, input logic [23:0] r);
    if (c != 0) return c - 24'd1;
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
      2'd1: return {8'b0, m_rel};
      2'd2: return {8'b0, m_cur};
      default: return CAL_EXP;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_ie, m_src, m_flag, m_irq, m_s1, m_s2, m_s3} <= '0;
      m_cur <= '0; m_rel <= '0;
    end else begin
      logic go, one;
      go  = m_en && !halt && (m_src || (m_s2 && !m_s3));
      one = go && (m_cur == 24'd1);
      m_s1 <= ref_in; m_s2 <= m_s1; m_s3 <= m_s2;
      if (wr && sel == 2'd2) begin
        m_cur <= '0; m_flag <= 1'b0; m_irq <= 1'b0;
      end else begin
        if (go) m_cur <= after_step(m_cur, m_rel);
        if (one) m_flag <= 1'b1;
        else if (rd && sel == 2'd0) m_flag <= 1'b0;
        m_irq <= one && m_ie;
      end
      if (wr && sel == 2'd0) {m_src, m_ie, m_en} <= wdata[2:0];
      if (wr && sel == 2'd1) m_rel <= wdata[23:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] s, input logic w, input logic r,
                     input logic [31:0] d, input string tag);
    sel = s; wr = w; rd = r; wdata = d;
    @(negedge clk);
    if (r) begin
      last_rd = rdata;
      check(tag, rdata, model_read(s));
    end
    check("R6 irq", {31'b0, irq}, {31'b0, m_irq});
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic [23:0] held;
    seed_dummy = $urandom(32'h1CE5);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cyc(2'd0, 0, 1, 0, "R1 ctrl"); check("R1 ctrl lit", last_rd, 32'h0);
    cyc(2'd1, 0, 1, 0, "R1 reload"); check("R1 reload lit", last_rd, 32'h0);
    cyc(2'd2, 0, 1, 0, "R1 current"); check("R1 current lit", last_rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R10 calibration, write ignored
    cyc(2'd3, 0, 1, 0, "R10 cal"); check("R10 cal lit", last_rd, 32'h0007A120);
    cyc(2'd3, 1, 0, 32'hFFFF_FFFF, "R10 wr");
    cyc(2'd3, 0, 1, 0, "R10 cal after wr"); check("R10 cal lit2", last_rd, 32'h0007A120);

    // R2 R3 core-clock counting with reload 3
    cyc(2'd1, 1, 0, 32'hFF00_0003, "R2 wr");
    cyc(2'd1, 0, 1, 0, "R2 reload"); check("R2 reload lit", last_rd, 32'h3);
    cyc(2'd0, 1, 0, 32'hFFFF_FFF7, "R2 ctl wr");
    cyc(2'd0, 0, 1, 0, "R2 ctl"); check("R2 ctl lit", last_rd & 32'h7, 32'h7);
    for (int i = 0; i < 12; i++) cyc(2'd2, 0, 1, 0, "R3 count");
    // R5 read-clear vs wrap in the same cycle
    for (int i = 0; i < 12; i++) cyc(2'd0, 0, 1, 0, "R5 flag");

    // R7 write current while counting
    cyc(2'd2, 1, 0, 32'h1234_5678, "R7 wr");
    cyc(2'd2, 0, 1, 0, "R7 cur"); check("R7 cur lit", last_rd, 32'h0);
    cyc(2'd0, 0, 1, 0, "R7 flag"); check("R7 flag lit", last_rd[16], 1'b0);
    for (int i = 0; i < 4; i++) cyc(2'd2, 1, 1, 32'h0, "R7 repeat");

    // R8 debug halt
    halt = 1'b1;
    cyc(2'd2, 0, 1, 0, "R8 a"); held = last_rd[23:0];
    repeat (3) cyc(2'd0, 0, 0, 0, "R8 idle");
    cyc(2'd2, 0, 1, 0, "R8 b"); check("R8 hold lit", last_rd, {8'b0, held});
    halt = 1'b0;

    // R11 run cleared
    cyc(2'd0, 1, 0, 32'h6, "R11 wr");
    cyc(2'd2, 0, 1, 0, "R11 a"); held = last_rd[23:0];
    repeat (3) cyc(2'd1, 0, 0, 0, "R11 idle");
    cyc(2'd2, 0, 1, 0, "R11 b"); check("R11 hold lit", last_rd, {8'b0, held});

    // R9 zero reload
    cyc(2'd1, 1, 0, 32'h0, "R9 rl");
    cyc(2'd2, 1, 0, 32'h0, "R9 clr");
    cyc(2'd0, 1, 0, 32'h7, "R9 run");
    for (int i = 0; i < 10; i++) cyc(2'd2, 0, 1, 0, "R9 cur");
    check("R9 cur lit", last_rd, 32'h0);
    cyc(2'd0, 0, 1, 0, "R9 flag"); check("R9 flag lit", last_rd[16], 1'b0);

    // R4 external reference
    cyc(2'd1, 1, 0, 32'h5, "R4 rl");
    cyc(2'd0, 1, 0, 32'h3, "R4 ctl");
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 0) ref_in = ~ref_in;
      cyc(2'd2, 0, 1, 0, "R4 cur");
    end

    // R6 interrupt enable clear: no pulse
    cyc(2'd1, 1, 0, 32'h2, "R6 rl");
    cyc(2'd0, 1, 0, 32'h5, "R6 ctl");
    for (int i = 0; i < 10; i++) begin
      cyc(2'd0, 0, 1, 0, "R6 flag");
      check("R6 irq off lit", {31'b0, irq}, 32'h0);
    end

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      logic [1:0] s;
      logic w, r;
      logic [31:0] d;
      s = 2'($urandom % 4);
      w = ($urandom % 8) == 0;
      r = ($urandom % 2) == 0;
      d = $urandom;
      if (s == 2'd1) d = d % 6;
      if (s == 2'd0) d[0] = ($urandom % 5) != 0;
      if (($urandom % 4) == 0) ref_in = ~ref_in;
      halt = ($urandom % 16) == 0;
      case (s)
        2'd0: cyc(s, w, r, d, "R5 rnd ctrl");
        2'd1: cyc(s, w, r, d, "R2 rnd reload");
        2'd2: cyc(s, w, r, d, "R3 rnd current");
        default: cyc(s, w, r, d, "R10 rnd cal");
      endcase
    end
    halt = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule